// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block gathers interrupt requests from up to 128 general-purpose pins and turns them into one request line toward a processor. The pins are grouped in banks of 32. Every pin has its own configuration word, which sets how the pin triggers, what arbitration priority it has, and whether it may wake the system from idle. Each bank has a write-one register that unmasks pins, one that masks them, and one that acknowledges latched edges. A read-only encoder register gives the number of the pin that software should service next.

Two further registers handle pin routing. A trigger-select register picks two pins whose synchronised levels are driven out as external DMA triggers. A device-select register marks pins that have been handed to their peripheral function. The pin multiplexer and the DMA engine are outside this block; it only drives their control lines.

All register writes take effect at the next clock edge. Reads are combinational from the address.

Top module: `gpic_top`

## Requirements
- R1: After reset every mask bit is 0, `cpu_irq` is low, and the encoder register (byte address 0x244) reads 0xFFFFFFFF.
- R2: Writing a 1 to the unmask register of bank b (0x200+4b) sets that pin's mask bit. Writing a 1 to the mask register (0x210+4b) clears it. Zero bits in either write leave the mask unchanged. Both addresses read back the bank's current mask. Pin p sits in bank p/32 at bit p%32.
- R3: A pin configured for rising edge (trigger code 3) latches pending two synchroniser stages after its input rises. It stays pending after the input falls, until a 1 is written to its bit in the bank's acknowledge/pending register (0x220+4b), which reads back the pending state.
- R4: Trigger code 4 latches on a falling edge only. Code 5 latches on both edges.
- R5: With trigger code 1 (high level), a pin reads pending while its input is 1. With code 2 (low level), it reads pending while its input is 0. An acknowledge has no effect on a level pin.
- R6: With trigger code 0 (off), a pin never reads pending, whatever its input does.
- R7: `cpu_irq` is high exactly when some pin is both pending and unmasked. A masked pin that is pending still reads pending but does not raise `cpu_irq`.
- R8: The encoder register returns the number of the pending, unmasked pin with the smallest priority value. When two pins have the same priority, the lower pin number wins.
- R9: `idle_wake` is the OR, over all pins, of the pin's wake bit AND its pending state. The mask does not take part.
- R10: The trigger-select register (0x240) holds a 7-bit pin number for channel 0 in bits 6:0 and one for channel 1 in bits 14:8. Bits 7 and 15 read 0. `dma_trig[n]` follows the synchronised level of the selected pin.
- R11: Writing a 1 to bank b's device-select register (0x230+4b) sets the matching `dev_sel` bit. Zero bits have no effect. The register reads back the bank's bits.
- R12: The configuration word for pin p sits at byte address 4p. Its layout is trigger code in bits 2:0, priority in bits 5:4 (0 is the highest priority), and wake enable in bit 8. Reads return the stored fields, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pins_in | input | NUM_PINS | Asynchronous pin inputs |
| cpu_irq | output | 1 | Request to the processor |
| idle_wake | output | 1 | Wake request from idle |
| dma_trig | output | 2 | Levels of the two selected trigger pins |
| dev_sel | output | NUM_PINS | Pins assigned to their device function |

## Verification
Each trigger type is exercised with rising, falling, held and released pin patterns, which shows whether a pin latches, follows its level, or ignores its input. Acknowledge writes go to both edge pins and level pins, which separates latched pending from live pending. The encoder is tried with four pins of mixed priorities, retired one at a time, which separates priority order from pin-number order. Masked pins, pins with the wake bit set, and pins chosen for the trigger outputs show that the request, wake and trigger paths are independent of one another.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
    localparam int ADDR_W    = 10;
    localparam int BANK_W    = 32;
    localparam int EN_BASE   = 'h200;
    localparam int DIS_BASE  = 'h210;
    localparam int PEND_BASE = 'h220;
    localparam int DEV_BASE  = 'h230;
    localparam int DMA_ADDR  = 'h240;
    localparam int ENC_ADDR  = 'h244;

    typedef enum logic [2:0] {
        TRIG_OFF  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_RISE = 3'd3,
        TRIG_FALL = 3'd4,
        TRIG_BOTH = 3'd5
    } trig_e;

    typedef struct packed {
        logic       wake;
        logic [1:0] prio;
        logic [2:0] trig;
    } pin_cfg_t;
endpackage

// File: rtl/gpic_pin_cell.sv
module gpic_pin_cell (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic [2:0] trig,
    input  logic       ack,
    output logic       lvl_sync,
    output logic       pend_raw
);
    import gpic_pkg::*;

    logic s1_q, s2_q, s3_q, latch_q;
    logic is_edge, rise, fall, edge_hit;

    assign rise = s2_q & ~s3_q;
    assign fall = ~s2_q & s3_q;

    always_comb begin
        is_edge  = 1'b0;
        edge_hit = 1'b0;
        unique case (trig)
            TRIG_RISE: begin is_edge = 1'b1; edge_hit = rise;        end
            TRIG_FALL: begin is_edge = 1'b1; edge_hit = fall;        end
            TRIG_BOTH: begin is_edge = 1'b1; edge_hit = rise | fall; end
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q    <= 1'b0;
            s2_q    <= 1'b0;
            s3_q    <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            s1_q <= pin_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (!is_edge)      latch_q <= 1'b0;
            else if (edge_hit) latch_q <= 1'b1;
            else if (ack)      latch_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (trig)
            TRIG_HIGH:                     pend_raw = s2_q;
            TRIG_LOW:                      pend_raw = ~s2_q;
            TRIG_RISE, TRIG_FALL, TRIG_BOTH: pend_raw = latch_q;
            default:                       pend_raw = 1'b0;
        endcase
    end

    assign lvl_sync = s2_q;
endmodule

// File: rtl/gpic_prio_arb.sv
module gpic_prio_arb #(
    parameter int NUM_PINS = 128,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic [NUM_PINS-1:0]   req,
    input  logic [2*NUM_PINS-1:0] prio_flat,
    output logic                  found,
    output logic [IDX_W-1:0]      win_idx
);
    logic [1:0] best;

    always_comb begin
        found   = 1'b0;
        best    = 2'd3;
        win_idx = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (req[i] && (!found || prio_flat[2*i +: 2] < best)) begin
                found   = 1'b1;
                best    = prio_flat[2*i +: 2];
                win_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/gpic_top.sv
module gpic_top #(
    parameter int NUM_PINS = 128,
    localparam int NUM_BANKS = NUM_PINS / 32,
    localparam int IDX_W     = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [9:0]          addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [NUM_PINS-1:0] pins_in,
    output logic                cpu_irq,
    output logic                idle_wake,
    output logic [1:0]          dma_trig,
    output logic [NUM_PINS-1:0] dev_sel
);
    import gpic_pkg::*;

    pin_cfg_t              cfg_q [NUM_PINS];
    logic [NUM_PINS-1:0]   mask_q, dev_q, ack_vec, pend_raw, lvl_sync, wake_vec;
    logic [2*NUM_PINS-1:0] prio_flat;
    logic [6:0]            dsel_q [2];
    logic                  enc_found;
    logic [IDX_W-1:0]      enc_idx;
    logic [31:0]           enc_word;

    function automatic logic hit(input logic [9:0] a, input int base, input int k);
        return a == 10'(base + 4*k);
    endfunction

    // acknowledge strobes per pin
    always_comb begin
        ack_vec = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (wr_en && hit(addr, PEND_BASE, b)) ack_vec[b*32 +: 32] = wdata;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
            gpic_pin_cell u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_in   (pins_in[gi]),
                .trig     (cfg_q[gi].trig),
                .ack      (ack_vec[gi]),
                .lvl_sync (lvl_sync[gi]),
                .pend_raw (pend_raw[gi])
            );
            assign prio_flat[2*gi +: 2] = cfg_q[gi].prio;
            assign wake_vec[gi]         = cfg_q[gi].wake & pend_raw[gi];
        end
    endgenerate

    gpic_prio_arb #(.NUM_PINS(NUM_PINS)) u_arb (
        .req       (pend_raw & mask_q),
        .prio_flat (prio_flat),
        .found     (enc_found),
        .win_idx   (enc_idx)
    );

    assign enc_word  = enc_found ? 32'(enc_idx) : 32'hFFFF_FFFF;
    assign cpu_irq   = |(pend_raw & mask_q);
    assign idle_wake = |wake_vec;
    assign dev_sel   = dev_q;

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '0;
            dev_q     <= '0;
            dsel_q[0] <= '0;
            dsel_q[1] <= '0;
            for (int i = 0; i < NUM_PINS; i++) cfg_q[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_PINS; i++)
                if (hit(addr, 0, i)) cfg_q[i] <= {wdata[8], wdata[5:4], wdata[2:0]};
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (hit(addr, EN_BASE, b))  mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] | wdata;
                if (hit(addr, DIS_BASE, b)) mask_q[b*32 +: 32] <= mask_q[b*32 +: 32] & ~wdata;
                if (hit(addr, DEV_BASE, b)) dev_q[b*32 +: 32]  <= dev_q[b*32 +: 32] | wdata;
            end
            if (addr == 10'(DMA_ADDR)) begin
                dsel_q[0] <= wdata[6:0];
                dsel_q[1] <= wdata[14:8];
            end
        end
    end

    // trigger outputs
    always_comb begin
        for (int n = 0; n < 2; n++)
            dma_trig[n] = (32'(dsel_q[n]) < NUM_PINS) ? lvl_sync[dsel_q[n]] : 1'b0;
    end

    // read mux
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_PINS; i++)
            if (hit(addr, 0, i))
                rdata = {23'd0, cfg_q[i].wake, 2'd0, cfg_q[i].prio, 1'b0, cfg_q[i].trig};
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit(addr, EN_BASE, b) || hit(addr, DIS_BASE, b)) rdata = mask_q[b*32 +: 32];
            if (hit(addr, PEND_BASE, b)) rdata = pend_raw[b*32 +: 32];
            if (hit(addr, DEV_BASE, b))  rdata = dev_q[b*32 +: 32];
        end
        if (addr == 10'(DMA_ADDR)) rdata = {16'd0, 1'b0, dsel_q[1], 1'b0, dsel_q[0]};
        if (addr == 10'(ENC_ADDR)) rdata = enc_word;
    end
endmodule

// File: rtl/gpic_chk.sv
module gpic_chk #(
    parameter int NUM_PINS = 128,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [9:0]          addr,
    input logic [31:0]         wdata,
    input logic                cpu_irq,
    input logic                idle_wake,
    input logic [31:0]         enc_word,
    input logic [NUM_PINS-1:0] mask_q,
    input logic [NUM_PINS-1:0] pend_raw,
    input logic [NUM_PINS-1:0] dev_sel
);
    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == (enc_word != 32'hFFFF_FFFF)); // R7

    AST_ENC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_word != 32'hFFFF_FFFF) |-> (pend_raw[enc_word[IDX_W-1:0]] && mask_q[enc_word[IDX_W-1:0]])); // R8

    AST_UNMASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 10'h200) |=> ((mask_q[31:0] & $past(wdata)) == $past(wdata))); // R2

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 10'h210) |=> ((mask_q[31:0] & $past(wdata)) == 32'd0)); // R2

    AST_WAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        idle_wake |-> (pend_raw != '0)); // R9

    AST_DEVSEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(dev_sel) & ~dev_sel) == '0)); // R11
endmodule

bind gpic_top gpic_chk #(.NUM_PINS(NUM_PINS)) u_gpic_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .cpu_irq   (cpu_irq),
    .idle_wake (idle_wake),
    .enc_word  (enc_word),
    .mask_q    (mask_q),
    .pend_raw  (pend_raw),
    .dev_sel   (dev_sel)
);

// File: tb/test_gpic_top.sv
module test_gpic_top;
    localparam int NP = 128;
    localparam logic [9:0] A_EN = 10'h200, A_DIS = 10'h210, A_PEND = 10'h220,
                           A_DEV = 10'h230, A_DMA = 10'h240, A_ENC = 10'h244;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [9:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pins_in = '0;
    logic          cpu_irq, idle_wake;
    logic [1:0]    dma_trig;
    logic [NP-1:0] dev_sel;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    gpic_top #(.NUM_PINS(NP)) i_gpic_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pins_in(pins_in), .cpu_irq(cpu_irq), .idle_wake(idle_wake),
        .dma_trig(dma_trig), .dev_sel(dev_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic cfg(input int pin, input int trig, input int prio, input int wake);
        wr(10'(4*pin), 32'(trig) | (32'(prio) << 4) | (32'(wake) << 8));
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_EN, v);  chk("R1 mask", v, 0);
        rd(A_ENC, v); chk("R1 encoder", v, 32'hFFFF_FFFF);
        chk("R1 cpu_irq", 32'(cpu_irq), 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(A_EN + 4, 32'hF0);
        rd(A_EN + 4, v);  chk("R2 unmask", v, 32'hF0);
        wr(A_EN + 4, 32'h0);
        rd(A_DIS + 4, v); chk("R2 zero write", v, 32'hF0);
        wr(A_DIS + 4, 32'h30);
        rd(A_EN + 4, v);  chk("R2 mask", v, 32'hC0);
        wr(A_DIS + 4, 32'hFFFF_FFFF);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        cfg(5, 3, 1, 0); wr(A_EN, 32'h20);
        pins_in[5] = 1'b1; settle();
        rd(A_PEND, v); chk("R3 latch", v, 32'h20);
        chk("R7 irq", 32'(cpu_irq), 1);
        rd(A_ENC, v);  chk("R8 single", v, 5);
        pins_in[5] = 1'b0; settle();
        rd(A_PEND, v); chk("R3 held", v, 32'h20);
        wr(A_PEND, 32'h20);
        rd(A_PEND, v); chk("R3 ack", v, 0);
        chk("R7 irq clear", 32'(cpu_irq), 0);
        wr(A_DIS, 32'h20);
    endtask

    task automatic t_fall_both();
        logic [31:0] v;
        cfg(6, 4, 1, 0); cfg(7, 5, 1, 0);
        pins_in[6] = 1'b1; pins_in[7] = 1'b1; settle();
        rd(A_PEND, v); chk("R4 fall/both on rise", v, 32'h80);
        wr(A_PEND, 32'hC0);
        pins_in[6] = 1'b0; pins_in[7] = 1'b0; settle();
        rd(A_PEND, v); chk("R4 fall/both on fall", v, 32'hC0);
        wr(A_PEND, 32'hC0);
        rd(A_PEND, v); chk("R4 ack", v, 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        cfg(40, 1, 1, 0); wr(A_EN + 4, 32'h100);
        pins_in[40] = 1'b1; settle();
        rd(A_PEND + 4, v); chk("R5 high", v, 32'h100);
        wr(A_PEND + 4, 32'h100);
        rd(A_PEND + 4, v); chk("R5 ack no effect", v, 32'h100);
        pins_in[40] = 1'b0; settle();
        rd(A_PEND + 4, v); chk("R5 high released", v, 0);
        cfg(41, 2, 1, 0); settle();
        rd(A_PEND + 4, v); chk("R5 low", v, 32'h200);
        pins_in[41] = 1'b1; settle();
        rd(A_PEND + 4, v); chk("R5 low released", v, 0);
        wr(A_DIS + 4, 32'h100);
    endtask

    task automatic t_off();
        logic [31:0] v;
        cfg(9, 0, 0, 0);
        pins_in[9] = 1'b1; settle();
        rd(A_PEND, v); chk("R6 off high", v, 0);
        pins_in[9] = 1'b0; settle();
        rd(A_PEND, v); chk("R6 off low", v, 0);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        cfg(10, 3, 0, 0);
        pins_in[10] = 1'b1; settle();
        rd(A_PEND, v); chk("R7 masked pending", v, 32'h400);
        chk("R7 masked no irq", 32'(cpu_irq), 0);
        rd(A_ENC, v);  chk("R7 masked encoder", v, 32'hFFFF_FFFF);
        wr(A_PEND, 32'h400); pins_in[10] = 1'b0;
    endtask

    task automatic t_encoder();
        logic [31:0] v;
        cfg(20, 3, 2, 0); cfg(70, 3, 0, 0); cfg(90, 3, 0, 0); cfg(3, 3, 3, 0);
        wr(A_EN, 32'h0010_0008); wr(A_EN + 8, 32'h0400_0040);
        pins_in[3] = 1'b1; pins_in[20] = 1'b1; pins_in[70] = 1'b1; pins_in[90] = 1'b1; settle();
        rd(A_ENC, v); chk("R8 prio then index", v, 70);
        wr(A_PEND + 8, 32'h40);
        rd(A_ENC, v); chk("R8 tie next", v, 90);
        wr(A_PEND + 8, 32'h0400_0000);
        rd(A_ENC, v); chk("R8 prio 2", v, 20);
        wr(A_PEND, 32'h0010_0000);
        rd(A_ENC, v); chk("R8 prio 3", v, 3);
        wr(A_PEND, 32'h8);
        rd(A_ENC, v); chk("R8 empty", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_wake();
        cfg(50, 1, 1, 1);
        pins_in[50] = 1'b1; settle();
        chk("R9 wake while masked", 32'(idle_wake), 1);
        chk("R9 no irq", 32'(cpu_irq), 0);
        cfg(50, 1, 1, 0);
        @(negedge clk);
        chk("R9 wake bit off", 32'(idle_wake), 0);
    endtask

    task automatic t_dma();
        logic [31:0] v;
        wr(A_DMA, {16'd0, 8'd100, 8'h80 | 8'd12});
        rd(A_DMA, v); chk("R10 readback", v, 32'h0000_640C);
        pins_in[12] = 1'b1; settle();
        chk("R10 chan0", 32'(dma_trig), 32'b01);
        pins_in[100] = 1'b1; settle();
        chk("R10 chan1", 32'(dma_trig), 32'b11);
    endtask

    task automatic t_dev();
        logic [31:0] v;
        wr(A_DEV + 12, 32'h1);
        chk("R11 dev_sel", 32'(dev_sel[96]), 1);
        wr(A_DEV + 12, 32'h0);
        rd(A_DEV + 12, v); chk("R11 zero write", v, 32'h1);
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        wr(10'(4*33), 32'hFFFF_FE24 | 32'h100);
        rd(10'(4*33), v); chk("R12 fields", v, 32'h124);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset(); t_mask(); t_rise(); t_fall_both(); t_level(); t_off();
        t_masked(); t_encoder(); t_wake(); t_dma(); t_dev(); t_cfg();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule